// File: doc/BRIEF.md
# Multiplexed Parallel Bus Master

This block is the host side of an 8-bit byte-wide parallel link on which addresses and data share the same wires. A peripheral tells the two apart by which strobe is pulsed. A separate address strobe latches an address byte, and a data strobe moves a data byte in either direction. A chip select frames every transfer. A direction line tells the peripheral whether the host writes or reads. The peripheral answers every data strobe on a wait line: it raises the line when it has accepted or presented the byte, and drops it again after the strobe ends.

The user side has one request port. The user gives a cycle kind, a byte (an address or write data) and a one-cycle start pulse. A one-cycle done pulse comes back with the byte read from the bus and an error flag. Every minimum interval on the bus counts in system-clock cycles and is set by a parameter: address setup, address strobe width, address hold, direction setup, data strobe width, data hold and the handshake timeout. The defaults suit a 100 MHz clock, with each nanosecond limit rounded up to whole cycles. A watchdog on the handshake frees the bus when the peripheral does not answer.

Top module: `mux_bus_master`

## Requirements
- R1: After reset, chip select, the direction line and both strobes are high (inactive), and the done pulse is low.
- R2: Kind code 0 is an address write. Chip select and the direction line go low with the address on the bus. The address strobe falls after ADDR_SETUP_CYC cycles and stays low exactly ADDR_PULSE_CYC cycles. The address stays on the bus for ADDR_HOLD_CYC cycles after the strobe rises, and chip select then rises together with the done pulse.
- R3: Chip select is low in every cycle in which either strobe is low, and the two strobes are never low together.
- R4: Kind code 1 is a data write. The direction line is low for DIR_SETUP_CYC cycles before the data strobe falls and stays unchanged while chip select is low. The write byte is on the bus while the data strobe is low and for DATA_HOLD_CYC cycles after it rises.
- R5: The data strobe stays low at least DATA_PULSE_CYC cycles. Except on a timeout, it rises only at a clock edge where the wait line is high. The low time is therefore the larger of DATA_PULSE_CYC and the cycle in which the wait line is first seen high.
- R6: In a read cycle the master's bus drivers are off from the start of the cycle, at least one cycle before the data strobe falls, and they stay off while the strobe is low.
- R7: Kind code 2 (and code 3, which is treated the same) is a data read with the direction line high. The byte on the bus is captured at the edge where the data strobe rises and is returned with the done pulse, with the error flag low.
- R8: If the wait line has not been seen high within TIMEOUT_CYC cycles of the data strobe falling, the strobe rises after exactly TIMEOUT_CYC cycles. The hold phase still runs, and the done pulse carries the error flag high.
- R9: No strobe falls while the wait line is high. If the wait line stays high for TIMEOUT_CYC cycles before the strobe, the cycle ends with no strobe at all: chip select rises and done is signalled with the error flag high.
- R10: A start pulse while a cycle is in progress is ignored. Each accepted start gives exactly one done pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_start_i | input | 1 | One-cycle pulse that starts a cycle |
| req_kind_i | input | 2 | Cycle kind: 0 address write, 1 data write, 2 or 3 data read |
| req_data_i | input | DATA_W | Address or write byte |
| rsp_done_o | output | 1 | One-cycle pulse at the end of a cycle |
| rsp_data_o | output | DATA_W | Byte captured by the last read |
| rsp_err_o | output | 1 | Handshake timeout flag, valid with done |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_wr_no | output | 1 | Direction line, low for write, high for read |
| bus_astb_no | output | 1 | Address strobe, active low |
| bus_dstb_no | output | 1 | Data strobe, active low |
| bus_wait_i | input | 1 | Peripheral handshake line |
| bus_data_io | inout | DATA_W | Shared address/data bus |

## Verification
The bound checker watches several rules in every cycle: chip select framing both strobes, the two strobes never overlapping, and no strobe starting while the wait line is high. It also checks that the data strobe never rises before its minimum width and never without the handshake or the timeout, that the drivers are off around read strobes, and that the direction line is steady inside a cycle. Only the directed scenarios can show the exact setup, width and hold lengths, the bytes on the bus and the byte returned by a read, and the strobe stretching behind a slow peripheral. The same holds for both timeout paths with their error flag, and for a start pulse that is dropped while the master is busy.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    typedef enum logic [1:0] {
        KIND_ADDR_WR = 2'd0,
        KIND_DATA_WR = 2'd1,
        KIND_DATA_RD = 2'd2,
        KIND_RD_ALT  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } seq_st_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic kind_is_read(input kind_e k);
        return (k == KIND_DATA_RD) || (k == KIND_RD_ALT);
    endfunction

endpackage

// File: rtl/mbm_cycle_timer.sv
// Loadable down-counter; zero_o is high once the loaded count has run out.
module mbm_cycle_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/mbm_bus_pad.sv
// Tri-state driver and receiver for the shared byte bus.
module mbm_bus_pad #(
    parameter int DATA_W = 8
) (
    input  logic              oe_i,
    input  logic [DATA_W-1:0] dout_i,
    output logic [DATA_W-1:0] din_o,
    inout  wire  [DATA_W-1:0] pad_io
);

    assign pad_io = oe_i ? dout_i : {DATA_W{1'bz}};
    assign din_o  = pad_io;

endmodule

// File: rtl/mbm_sequencer.sv
// Cycle sequencer: setup, strobe and hold phases for all three cycle kinds.
module mbm_sequencer
    import mbm_pkg::*;
#(
    parameter int DATA_W         = 8,
    parameter int CNT_W          = 5,
    parameter int ADDR_SETUP_CYC = 2,
    parameter int ADDR_PULSE_CYC = 2,
    parameter int ADDR_HOLD_CYC  = 1,
    parameter int DIR_SETUP_CYC  = 1,
    parameter int DATA_PULSE_CYC = 7,
    parameter int DATA_HOLD_CYC  = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [1:0]        kind_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wait_i,
    input  logic [DATA_W-1:0] bus_in_i,
    input  logic              ph_zero_i,
    input  logic              to_zero_i,
    output logic              ph_load_o,
    output logic [CNT_W-1:0]  ph_val_o,
    output logic              to_load_o,
    output logic              cs_no,
    output logic              wr_no,
    output logic              astb_no,
    output logic              dstb_no,
    output logic              oe_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o
);

    // Timer reload values: a phase of N cycles loads N-1.
    localparam logic [CNT_W-1:0] ASET_V   = CNT_W'(ADDR_SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] APULSE_V = CNT_W'(ADDR_PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] AHOLD_V  = CNT_W'(ADDR_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] DSET_V   = CNT_W'(DIR_SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] DPULSE_V = CNT_W'(DATA_PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] DHOLD_V  = CNT_W'(DATA_HOLD_CYC - 1);

    typedef struct packed {
        seq_st_e           st;
        kind_e             kind;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              err;
        logic              done;
        logic              cs_n;
        logic              wr_n;
        logic              astb_n;
        logic              dstb_n;
        logic              oe;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st:     ST_IDLE,
        kind:   KIND_ADDR_WR,
        wdata:  '0,
        rdata:  '0,
        err:    1'b0,
        done:   1'b0,
        cs_n:   1'b1,
        wr_n:   1'b1,
        astb_n: 1'b1,
        dstb_n: 1'b1,
        oe:     1'b0
    };

    seq_t  seq_d, seq_q;
    kind_e req_kind;

    assign req_kind = kind_e'(kind_i);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        ph_load_o  = 1'b0;
        ph_val_o   = '0;
        to_load_o  = 1'b0;

        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st    = ST_SETUP;
                    seq_d.kind  = req_kind;
                    seq_d.wdata = wdata_i;
                    seq_d.err   = 1'b0;
                    seq_d.cs_n  = 1'b0;
                    seq_d.wr_n  = kind_is_read(req_kind);
                    seq_d.oe    = !kind_is_read(req_kind);
                    ph_load_o   = 1'b1;
                    ph_val_o    = (req_kind == KIND_ADDR_WR) ? ASET_V : DSET_V;
                    to_load_o   = 1'b1;
                end
            end

            ST_SETUP: begin
                if (ph_zero_i && !wait_i) begin
                    seq_d.st = ST_STROBE;
                    if (seq_q.kind == KIND_ADDR_WR) begin
                        seq_d.astb_n = 1'b0;
                        ph_val_o     = APULSE_V;
                    end else begin
                        seq_d.dstb_n = 1'b0;
                        ph_val_o     = DPULSE_V;
                    end
                    ph_load_o = 1'b1;
                    to_load_o = 1'b1;
                end else if (to_zero_i) begin
                    // wait line never came low: abandon without a strobe
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                    seq_d.err  = 1'b1;
                    seq_d.cs_n = 1'b1;
                    seq_d.wr_n = 1'b1;
                    seq_d.oe   = 1'b0;
                end
            end

            ST_STROBE: begin
                if (seq_q.kind == KIND_ADDR_WR) begin
                    if (ph_zero_i) begin
                        seq_d.st     = ST_HOLD;
                        seq_d.astb_n = 1'b1;
                        ph_load_o    = 1'b1;
                        ph_val_o     = AHOLD_V;
                    end
                end else if (ph_zero_i && wait_i) begin
                    seq_d.st     = ST_HOLD;
                    seq_d.dstb_n = 1'b1;
                    if (kind_is_read(seq_q.kind)) begin
                        seq_d.rdata = bus_in_i;
                    end
                    ph_load_o = 1'b1;
                    ph_val_o  = DHOLD_V;
                end else if (to_zero_i) begin
                    seq_d.st     = ST_HOLD;
                    seq_d.dstb_n = 1'b1;
                    seq_d.err    = 1'b1;
                    ph_load_o    = 1'b1;
                    ph_val_o     = DHOLD_V;
                end
            end

            ST_HOLD: begin
                if (ph_zero_i) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                    seq_d.cs_n = 1'b1;
                    seq_d.wr_n = 1'b1;
                    seq_d.oe   = 1'b0;
                end
            end

            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cs_no   = seq_q.cs_n;
    assign wr_no   = seq_q.wr_n;
    assign astb_no = seq_q.astb_n;
    assign dstb_no = seq_q.dstb_n;
    assign oe_o    = seq_q.oe;
    assign wdata_o = seq_q.wdata;
    assign done_o  = seq_q.done;
    assign rdata_o = seq_q.rdata;
    assign err_o   = seq_q.err;

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
    import mbm_pkg::*;
#(
    parameter int DATA_W         = 8,
    parameter int ADDR_SETUP_CYC = 2,
    parameter int ADDR_PULSE_CYC = 2,
    parameter int ADDR_HOLD_CYC  = 1,
    parameter int DIR_SETUP_CYC  = 1,
    parameter int DATA_PULSE_CYC = 7,
    parameter int DATA_HOLD_CYC  = 1,
    parameter int TIMEOUT_CYC    = 20
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_start_i,
    input  logic [1:0]        req_kind_i,
    input  logic [DATA_W-1:0] req_data_i,
    output logic              rsp_done_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              rsp_err_o,
    output logic              bus_cs_no,
    output logic              bus_wr_no,
    output logic              bus_astb_no,
    output logic              bus_dstb_no,
    input  logic              bus_wait_i,
    inout  wire  [DATA_W-1:0] bus_data_io
);

    localparam int LONGEST = max_of(TIMEOUT_CYC,
                             max_of(max_of(ADDR_SETUP_CYC, ADDR_PULSE_CYC),
                             max_of(max_of(ADDR_HOLD_CYC, DIR_SETUP_CYC),
                                    max_of(DATA_PULSE_CYC, DATA_HOLD_CYC))));
    localparam int CNT_W = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] TO_V = CNT_W'(TIMEOUT_CYC - 1);

    logic              ph_load, ph_zero, to_load, to_zero;
    logic [CNT_W-1:0]  ph_val;
    logic              drv_en;
    logic [DATA_W-1:0] drv_data, bus_in;

    mbm_cycle_timer #(.CNT_W(CNT_W)) i_phase_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (ph_load),
        .val_i  (ph_val),
        .zero_o (ph_zero)
    );

    mbm_cycle_timer #(.CNT_W(CNT_W)) i_timeout_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (to_load),
        .val_i  (TO_V),
        .zero_o (to_zero)
    );

    mbm_bus_pad #(.DATA_W(DATA_W)) i_pad (
        .oe_i   (drv_en),
        .dout_i (drv_data),
        .din_o  (bus_in),
        .pad_io (bus_data_io)
    );

    mbm_sequencer #(
        .DATA_W         (DATA_W),
        .CNT_W          (CNT_W),
        .ADDR_SETUP_CYC (ADDR_SETUP_CYC),
        .ADDR_PULSE_CYC (ADDR_PULSE_CYC),
        .ADDR_HOLD_CYC  (ADDR_HOLD_CYC),
        .DIR_SETUP_CYC  (DIR_SETUP_CYC),
        .DATA_PULSE_CYC (DATA_PULSE_CYC),
        .DATA_HOLD_CYC  (DATA_HOLD_CYC)
    ) i_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (req_start_i),
        .kind_i    (req_kind_i),
        .wdata_i   (req_data_i),
        .wait_i    (bus_wait_i),
        .bus_in_i  (bus_in),
        .ph_zero_i (ph_zero),
        .to_zero_i (to_zero),
        .ph_load_o (ph_load),
        .ph_val_o  (ph_val),
        .to_load_o (to_load),
        .cs_no     (bus_cs_no),
        .wr_no     (bus_wr_no),
        .astb_no   (bus_astb_no),
        .dstb_no   (bus_dstb_no),
        .oe_o      (drv_en),
        .wdata_o   (drv_data),
        .done_o    (rsp_done_o),
        .rdata_o   (rsp_data_o),
        .err_o     (rsp_err_o)
    );

endmodule

// File: rtl/mbm_checker.sv
module mbm_checker #(
    parameter int DATA_PULSE_CYC = 7
) (
    input logic clk_i,
    input logic rst_ni,
    input logic cs_n_i,
    input logic wr_n_i,
    input logic astb_n_i,
    input logic dstb_n_i,
    input logic wait_i,
    input logic oe_i,
    input logic to_zero_i,
    input logic done_i
);

    localparam int CW = $clog2(DATA_PULSE_CYC + 1) + 1;
    localparam logic [CW-1:0] LO_MAX = '1;

    logic [CW-1:0] lo_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lo_cnt_q <= '0;
        end else if (!dstb_n_i) begin
            if (lo_cnt_q != LO_MAX) lo_cnt_q <= lo_cnt_q + 1'b1;
        end else begin
            lo_cnt_q <= '0;
        end
    end

    // R3
    cs_frames_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!astb_n_i || !dstb_n_i) |-> !cs_n_i);

    // R3
    single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!astb_n_i && !dstb_n_i));

    // R4
    dir_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_n_i && !$past(cs_n_i)) |-> $stable(wr_n_i));

    // R5
    dstb_min_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dstb_n_i) |-> (lo_cnt_q >= CW'(DATA_PULSE_CYC)));

    // R5
    dstb_handshake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dstb_n_i) |-> ($past(wait_i) || $past(to_zero_i)));

    // R6
    no_drive_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dstb_n_i && wr_n_i) |-> !oe_i);

    // R6
    turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(dstb_n_i) && wr_n_i) |-> !$past(oe_i));

    // R9
    no_strobe_on_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(dstb_n_i) || $fell(astb_n_i)) |-> !$past(wait_i));

    // R10
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

endmodule

bind mux_bus_master mbm_checker #(
    .DATA_PULSE_CYC (DATA_PULSE_CYC)
) i_mbm_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_i    (bus_cs_no),
    .wr_n_i    (bus_wr_no),
    .astb_n_i  (bus_astb_no),
    .dstb_n_i  (bus_dstb_no),
    .wait_i    (bus_wait_i),
    .oe_i      (drv_en),
    .to_zero_i (to_zero),
    .done_i    (rsp_done_o)
);

// File: tb/test_mux_bus_master.sv
`timescale 1ns/1ps
module test_mux_bus_master;

    localparam int ASET   = 2;
    localparam int APULSE = 2;
    localparam int AHOLD  = 1;
    localparam int DSET   = 1;
    localparam int DPULSE = 7;
    localparam int DHOLD  = 1;
    localparam int TMO    = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_start = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [7:0] req_data = 8'h00;
    logic       rsp_done, rsp_err;
    logic [7:0] rsp_data;
    logic       cs_n, wr_n, astb_n, dstb_n;
    logic       wait_l;
    wire  [7:0] bus_w;

    // peripheral model controls
    logic       p_respond = 1'b1;
    logic       p_stuck = 1'b0;
    int         p_lat = 2;
    int         p_cnt;
    logic [7:0] p_rdval = 8'h00;
    logic       periph_drv;

    int n_tests = 0;
    int n_fail = 0;

    // monitor state
    int   m_pre, m_alo, m_dlo, m_post, m_done, m_bus_bad, m_wr_bad, m_rel_bad;
    bit   m_seen;
    logic m_prev_dstb, m_prev_wait;
    logic [7:0] m_exp_bus;
    logic m_exp_wr;
    bit   m_exp_drive, m_allow_to;

    always #2 clk = ~clk;

    assign periph_drv = !dstb_n && wr_n;
    assign bus_w = periph_drv ? p_rdval : 8'bz;

    mux_bus_master i_mux_bus_master (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_start_i (req_start),
        .req_kind_i  (req_kind),
        .req_data_i  (req_data),
        .rsp_done_o  (rsp_done),
        .rsp_data_o  (rsp_data),
        .rsp_err_o   (rsp_err),
        .bus_cs_no   (cs_n),
        .bus_wr_no   (wr_n),
        .bus_astb_no (astb_n),
        .bus_dstb_no (dstb_n),
        .bus_wait_i  (wait_l),
        .bus_data_io (bus_w)
    );

    // peripheral handshake model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_l <= 1'b0;
            p_cnt  <= 0;
        end else if (p_stuck) begin
            wait_l <= 1'b1;
        end else if (!dstb_n) begin
            p_cnt <= p_cnt + 1;
            if (p_respond && p_cnt >= p_lat) wait_l <= 1'b1;
        end else begin
            p_cnt  <= 0;
            wait_l <= 1'b0;
        end
    end

    // bus monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n && astb_n && dstb_n && !m_seen) m_pre++;
            if (!astb_n) begin
                m_alo++;
                m_seen = 1'b1;
                if (bus_w !== m_exp_bus) m_bus_bad++;
                if (wr_n !== m_exp_wr) m_wr_bad++;
            end
            if (!dstb_n) begin
                m_dlo++;
                m_seen = 1'b1;
                if (m_exp_drive && bus_w !== m_exp_bus) m_bus_bad++;
                if (wr_n !== m_exp_wr) m_wr_bad++;
            end
            if (m_seen && !cs_n && astb_n && dstb_n) begin
                m_post++;
                if (m_exp_drive && bus_w !== m_exp_bus) m_bus_bad++;
            end
            if (rsp_done) m_done++;
            if (!m_prev_dstb && dstb_n && !m_prev_wait && !m_allow_to) m_rel_bad++;
        end
        m_prev_dstb = dstb_n;
        m_prev_wait = wait_l;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon(input logic [7:0] eb, input logic ew, input bit ed);
        m_pre = 0; m_alo = 0; m_dlo = 0; m_post = 0; m_done = 0;
        m_bus_bad = 0; m_wr_bad = 0; m_rel_bad = 0; m_seen = 1'b0;
        m_exp_bus = eb; m_exp_wr = ew; m_exp_drive = ed;
    endtask

    task automatic run_cycle(input logic [1:0] k, input logic [7:0] d,
                             output logic [7:0] rd, output logic er, output bit got);
        @(posedge clk); #1;
        req_start = 1'b1; req_kind = k; req_data = d;
        @(posedge clk); #1;
        req_start = 1'b0;
        got = 1'b0; rd = 8'h00; er = 1'b0;
        for (int i = 0; i < 400 && !got; i++) begin
            @(negedge clk);
            if (rsp_done) begin
                got = 1'b1; rd = rsp_data; er = rsp_err;
            end
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        // R1: all bus controls idle, no done
        chk(cs_n === 1'b1, "R1", "cs_n after reset", int'(cs_n), 1);
        chk(wr_n === 1'b1, "R1", "wr_n after reset", int'(wr_n), 1);
        chk(astb_n === 1'b1, "R1", "astb_n after reset", int'(astb_n), 1);
        chk(dstb_n === 1'b1, "R1", "dstb_n after reset", int'(dstb_n), 1);
        chk(rsp_done === 1'b0, "R1", "done after reset", int'(rsp_done), 0);
    endtask

    task automatic t_addr_write(input logic [7:0] a);
        logic [7:0] rd; logic er; bit got;
        clear_mon(a, 1'b0, 1'b1);
        run_cycle(2'd0, a, rd, er, got);
        chk(got, "R2", "address write done", int'(got), 1);
        chk(m_pre == ASET, "R2", "address setup cycles", m_pre, ASET);
        chk(m_alo == APULSE, "R2", "address strobe width", m_alo, APULSE);
        chk(m_post == AHOLD, "R2", "address hold cycles", m_post, AHOLD);
        chk(m_bus_bad == 0 && m_wr_bad == 0, "R2", "address/dir on bus", m_bus_bad + m_wr_bad, 0);
        chk(m_dlo == 0, "R3", "no data strobe in address cycle", m_dlo, 0);
    endtask

    task automatic t_data_write(input logic [7:0] d);
        logic [7:0] rd; logic er; bit got;
        p_lat = 2; p_respond = 1'b1;
        clear_mon(d, 1'b0, 1'b1);
        run_cycle(2'd1, d, rd, er, got);
        chk(got && !er, "R4", "write done without error", int'(er), 0);
        chk(m_pre == DSET, "R4", "direction setup cycles", m_pre, DSET);
        chk(m_post == DHOLD, "R4", "write data hold cycles", m_post, DHOLD);
        chk(m_bus_bad == 0 && m_wr_bad == 0, "R4", "write byte and dir on bus", m_bus_bad + m_wr_bad, 0);
        chk(m_dlo == DPULSE, "R5", "data strobe minimum width", m_dlo, DPULSE);
        chk(m_alo == 0, "R3", "no address strobe in data cycle", m_alo, 0);
    endtask

    task automatic t_data_read(input logic [1:0] k, input logic [7:0] v);
        logic [7:0] rd; logic er; bit got;
        p_lat = 2; p_respond = 1'b1; p_rdval = v;
        clear_mon(8'h00, 1'b1, 1'b0);
        run_cycle(k, 8'hA5, rd, er, got);
        chk(got, "R7", "read done", int'(got), 1);
        chk(rd == v, "R7", "read byte returned", int'(rd), int'(v));
        chk(!er, "R7", "read error flag", int'(er), 0);
        chk(m_wr_bad == 0, "R7", "dir high during read", m_wr_bad, 0);
        chk(m_pre == DSET, "R6", "read setup cycles before strobe", m_pre, DSET);
        chk(m_rel_bad == 0, "R5", "read strobe released on wait", m_rel_bad, 0);
    endtask

    task automatic t_slow_wait;
        logic [7:0] rd; logic er; bit got;
        p_lat = 12; p_respond = 1'b1; p_rdval = 8'h3C;
        clear_mon(8'h00, 1'b1, 1'b0);
        run_cycle(2'd2, 8'h00, rd, er, got);
        // R5: strobe stretched to the wait response (latency + 2 cycles)
        chk(m_dlo == 14, "R5", "stretched strobe width", m_dlo, 14);
        chk(m_rel_bad == 0, "R5", "release only with wait high", m_rel_bad, 0);
        chk(rd == 8'h3C && !er, "R7", "slow read byte", int'(rd), 8'h3C);
        p_lat = 2;
    endtask

    task automatic t_timeout;
        logic [7:0] rd; logic er; bit got;
        p_respond = 1'b0; m_allow_to = 1'b1;
        clear_mon(8'h5A, 1'b0, 1'b1);
        run_cycle(2'd1, 8'h5A, rd, er, got);
        chk(got, "R8", "timeout cycle done", int'(got), 1);
        chk(er, "R8", "timeout error flag", int'(er), 1);
        chk(m_dlo == TMO, "R8", "strobe low until timeout", m_dlo, TMO);
        chk(m_post == DHOLD, "R8", "hold after timeout", m_post, DHOLD);
        p_respond = 1'b1; m_allow_to = 1'b0;
    endtask

    task automatic t_wait_stuck;
        logic [7:0] rd; logic er; bit got;
        @(posedge clk); #1; p_stuck = 1'b1;
        repeat (2) @(posedge clk);
        clear_mon(8'h11, 1'b0, 1'b1);
        run_cycle(2'd1, 8'h11, rd, er, got);
        chk(got && er, "R9", "stuck wait aborts with error", int'(er), 1);
        chk(m_dlo == 0 && m_alo == 0, "R9", "no strobe while wait high", m_dlo + m_alo, 0);
        chk(m_pre == TMO, "R9", "cs low cycles before abort", m_pre, TMO);
        chk(cs_n === 1'b1, "R9", "cs released after abort", int'(cs_n), 1);
        @(posedge clk); #1; p_stuck = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic t_busy_ignore;
        int seen;
        p_lat = 2; p_respond = 1'b1;
        clear_mon(8'hC3, 1'b0, 1'b1);
        @(posedge clk); #1;
        req_start = 1'b1; req_kind = 2'd1; req_data = 8'hC3;
        @(posedge clk); #1;
        req_start = 1'b0;
        repeat (3) @(posedge clk); #1;
        req_start = 1'b1; req_kind = 2'd0; req_data = 8'h77;
        @(posedge clk); #1;
        req_start = 1'b0;
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (rsp_done) seen++;
        end
        // R10: the second start during the write is dropped
        chk(m_done == 1, "R10", "done pulses per accepted start", m_done, 1);
        chk(seen == 1, "R10", "done observed once", seen, 1);
        chk(m_alo == 0, "R10", "ignored start made no address strobe", m_alo, 0);
        chk(m_bus_bad == 0, "R10", "bus kept first write byte", m_bus_bad, 0);
    endtask

    initial begin
        m_allow_to = 1'b0;
        m_prev_dstb = 1'b1;
        m_prev_wait = 1'b0;
        clear_mon(8'h00, 1'b1, 1'b0);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_addr_write(8'h5C);
        t_addr_write(8'hA3);
        t_data_write(8'h96);
        t_data_write(8'h0F);
        t_data_read(2'd2, 8'hE1);
        t_data_read(2'd3, 8'h42);
        t_slow_wait();
        t_timeout();
        t_data_write(8'h81);
        t_wait_stuck();
        t_busy_ignore();
        t_addr_write(8'hFF);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule